// File: doc/BRIEF.md
# Strap-Sized BAR Window Decoder

This block keeps three memory base-address registers: a control-register window, an SRAM window and a DRAM window. For each address presented with a valid strobe, it decides which window, if any, claims the address. It reports the winning window and the offset inside it on the next clock edge. The size of each window is a power of two, set by a size exponent. The control-register window has a fixed size. The other two take their size from one of two sources. When local firmware brings the unit up, it writes a 4-bit size code and a prefetchable flag into a per-window mask register. When an external host brings the unit up, two strap pins per window pick from a smaller set of large sizes.

A BAR reads back with every bit below its window size forced to zero. This lets a host write all ones and read back the size. The prefetchable flag sits at bit 3 of the value read back. A window whose size resolves to zero is switched off: it claims no address and reads back as zero. The block only decodes addresses; it moves no data.

Top module: `bwd_top`

## Requirements
- R1: The control-register window is always enabled and is 2^20 bytes. Its BAR reads back with bits 19:0 zero, so writing 0xFFFFFFFF reads back 0xFFF00000, and an address that hits it has an offset below 2^20.
- R2: With `host_mode` low, SRAM mask code c in 1..12 gives a window of 2^(16+c) bytes (128 KB up to 256 MB). Codes 0 and 13..15 switch the window off.
- R3: With `host_mode` low, DRAM mask code c in 1..11 gives a window of 2^(19+c) bytes (1 MB up to 1 GB). Codes 0 and 12..15 switch the window off.
- R4: With `host_mode` high, the SRAM window is 2^(25+s) bytes, where s is `sram_strap` (32 MB to 256 MB). The SRAM mask size code is ignored.
- R5: With `host_mode` high, the DRAM window is 2^(27+s) bytes, where s is `dram_strap` (128 MB to 1 GB). The DRAM mask size code is ignored.
- R6: A switched-off window never hits, and its BAR reads back as zero.
- R7: An enabled SRAM or DRAM BAR reads back as the stored value with bits below the window size cleared, bit 3 equal to that window's mask prefetchable flag (in either mode), and bits 2:0 zero. The control-register BAR always has bit 3 zero.
- R8: An address hits an enabled window when every address bit at or above the size exponent equals the matching BAR bit. The reported offset is the address bits below the exponent.
- R9: When several windows hit, the control-register window wins over SRAM, and SRAM wins over DRAM. `hit_idx` is 0 for control-register, 1 for SRAM, 2 for DRAM and 3 for no hit. At most one hit flag is set.
- R10: The outputs are registered. `addr_vld` high at an edge gives `hit_vld` high with that address's decode after the edge. `addr_vld` low gives `hit_vld` low, all flags low, `hit_idx` 3 and offset 0 after the edge, and this holds on back-to-back valid cycles.
- R11: After reset, all BARs hold zero, both mask registers hold code 0 with the flag clear, and the outputs read `hit_vld` 0, `hit_idx` 3, offset 0.
- R12: A mask write with `msk_sel` 0 (control-register) or 3 changes no window size, flag or BAR readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1: sizes come from the strap pins; 0: sizes come from the mask codes |
| sram_strap | input | 2 | SRAM size select used when host_mode is high |
| dram_strap | input | 2 | DRAM size select used when host_mode is high |
| msk_we | input | 1 | Mask register write strobe |
| msk_sel | input | 2 | Mask target: 1 SRAM, 2 DRAM, others ignored |
| msk_code | input | 4 | Size code written to the mask register |
| msk_pf | input | 1 | Prefetchable flag written to the mask register |
| bar_we | input | 1 | BAR write strobe |
| bar_sel | input | 2 | BAR target: 0 control-register, 1 SRAM, 2 DRAM |
| bar_wdata | input | ADDR_W | BAR write data |
| rd_sel | input | 2 | BAR readback select (3 reads zero) |
| rd_data | output | ADDR_W | Combinational BAR readback |
| addr | input | ADDR_W | Address to decode |
| addr_vld | input | 1 | Address valid |
| hit_vld | output | 1 | Registered decode result valid |
| hit_csr | output | 1 | Control-register window hit |
| hit_sram | output | 1 | SRAM window hit |
| hit_dram | output | 1 | DRAM window hit |
| hit_idx | output | 2 | Winning window index |
| hit_off | output | ADDR_W | Offset inside the winning window |

## Verification
The bound checker watches the following on every cycle:
- the hit flags are one-hot or idle and agree with the index;
- an idle cycle empties the outputs;
- each offset stays under the largest size its window can take;
- the attribute bits of the readback never carry stray values.

Only the bench's sweeps can show that the size chosen for each code and strap is correct and that the edges of each window land exactly on the right address. They also show the priority between overlapping windows and the cases where mask writes to the wrong target or in the wrong mode are ignored.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

   localparam int unsigned CODE_W = 4;
   localparam int unsigned EXP_W  = 6;
   localparam int unsigned PF_BIT = 3;

   typedef enum logic [1:0] {
      WIN_CSR  = 2'd0,
      WIN_SRAM = 2'd1,
      WIN_DRAM = 2'd2,
      WIN_NONE = 2'd3
   } win_e;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              pf;
   } msk_t;

   // exponent 0 encodes a switched-off window
   function automatic logic [EXP_W-1:0] sram_local_exp(input logic [CODE_W-1:0] c);
      if (c >= 4'd1 && c <= 4'd12) return EXP_W'(16) + EXP_W'(c);
      return '0;
   endfunction

   function automatic logic [EXP_W-1:0] dram_local_exp(input logic [CODE_W-1:0] c);
      if (c >= 4'd1 && c <= 4'd11) return EXP_W'(19) + EXP_W'(c);
      return '0;
   endfunction

   function automatic logic [EXP_W-1:0] window_exp(
      input int unsigned       kind,
      input logic              host,
      input logic [1:0]        strap,
      input logic [CODE_W-1:0] code,
      input int unsigned       csr_l,
      input int unsigned       sram_sl,
      input int unsigned       dram_sl);
      logic [EXP_W-1:0] loc, strapped, r;
      if (kind == 1) begin
         loc      = sram_local_exp(code);
         strapped = EXP_W'(sram_sl) + EXP_W'(strap);
      end else begin
         loc      = dram_local_exp(code);
         strapped = EXP_W'(dram_sl) + EXP_W'(strap);
      end
      r = host ? strapped : loc;
      if (kind == 0) r = EXP_W'(csr_l);
      return r;
   endfunction

endpackage

// File: rtl/bwd_prio.sv
module bwd_prio
   import bwd_pkg::*;
(
   input  logic [2:0] hit,
   output win_e       idx
);

   always_comb begin
      if (hit[0])      idx = WIN_CSR;
      else if (hit[1]) idx = WIN_SRAM;
      else if (hit[2]) idx = WIN_DRAM;
      else             idx = WIN_NONE;
   end

endmodule

// File: rtl/bwd_window.sv
module bwd_window
   import bwd_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned KIND            = 0,
   parameter int unsigned CSR_LOG2        = 20,
   parameter int unsigned SRAM_STRAP_LOG2 = 25,
   parameter int unsigned DRAM_STRAP_LOG2 = 27
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_mode,
   input  logic [1:0]        strap,
   input  logic              msk_we,
   input  logic [CODE_W-1:0] msk_code,
   input  logic              msk_pf,
   input  logic              bar_we,
   input  logic [ADDR_W-1:0] bar_wdata,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] off,
   output logic [ADDR_W-1:0] rd
);

   msk_t              msk_q;
   logic [ADDR_W-1:0] bar_q;
   logic [EXP_W-1:0]  exp_w;
   logic [ADDR_W-1:0] lomask;
   logic              en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msk_q <= '0;
         bar_q <= '0;
      end else begin
         if (msk_we) msk_q <= '{code: msk_code, pf: msk_pf};
         if (bar_we) bar_q <= bar_wdata;
      end
   end

   assign exp_w  = window_exp(KIND, host_mode, strap, msk_q.code,
                              CSR_LOG2, SRAM_STRAP_LOG2, DRAM_STRAP_LOG2);
   assign en     = (exp_w != '0);
   assign lomask = en ? ((ADDR_W'(1) << exp_w) - ADDR_W'(1)) : '0;

   assign hit = en && ((addr & ~lomask) == (bar_q & ~lomask));
   assign off = addr & lomask;
   assign rd  = en ? ((bar_q & ~lomask) | (ADDR_W'(msk_q.pf) << PF_BIT)) : '0;

endmodule

// File: rtl/bwd_top.sv
module bwd_top
   import bwd_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned CSR_LOG2        = 20,
   parameter int unsigned SRAM_STRAP_LOG2 = 25,
   parameter int unsigned DRAM_STRAP_LOG2 = 27
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_mode,
   input  logic [1:0]        sram_strap,
   input  logic [1:0]        dram_strap,
   input  logic              msk_we,
   input  logic [1:0]        msk_sel,
   input  logic [3:0]        msk_code,
   input  logic              msk_pf,
   input  logic              bar_we,
   input  logic [1:0]        bar_sel,
   input  logic [ADDR_W-1:0] bar_wdata,
   input  logic [1:0]        rd_sel,
   output logic [ADDR_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] addr,
   input  logic              addr_vld,
   output logic              hit_vld,
   output logic              hit_csr,
   output logic              hit_sram,
   output logic              hit_dram,
   output logic [1:0]        hit_idx,
   output logic [ADDR_W-1:0] hit_off
);

   localparam int unsigned N_WIN = 3;

   // elaboration-time parameter checks
   if (ADDR_W < 31 || ADDR_W > 64) begin : g_bad_aw
      $error("bwd_top: ADDR_W must be 31..64");
   end
   if (CSR_LOG2 < 4 || CSR_LOG2 >= ADDR_W) begin : g_bad_csr
      $error("bwd_top: CSR_LOG2 out of range");
   end
   if (SRAM_STRAP_LOG2 + 3 >= ADDR_W || DRAM_STRAP_LOG2 + 3 >= ADDR_W) begin : g_bad_strap
      $error("bwd_top: strap sizes exceed address width");
   end

   logic [N_WIN-1:0]  hit_w;
   logic [ADDR_W-1:0] off_w [4];
   logic [ADDR_W-1:0] rd_w  [4];
   win_e              win;

   for (genvar i = 0; i < N_WIN; i++) begin : g_win
      logic [1:0] strap_i;
      logic       mwe_i;
      if (i == 1) begin : g_s
         assign strap_i = sram_strap;
      end else if (i == 2) begin : g_d
         assign strap_i = dram_strap;
      end else begin : g_c
         assign strap_i = 2'b00;
      end
      assign mwe_i = (i != 0) && msk_we && (msk_sel == 2'(i));

      bwd_window #(
         .ADDR_W         (ADDR_W),
         .KIND           (i),
         .CSR_LOG2       (CSR_LOG2),
         .SRAM_STRAP_LOG2(SRAM_STRAP_LOG2),
         .DRAM_STRAP_LOG2(DRAM_STRAP_LOG2)
      ) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .host_mode(host_mode),
         .strap    (strap_i),
         .msk_we   (mwe_i),
         .msk_code (msk_code),
         .msk_pf   (msk_pf),
         .bar_we   (bar_we && (bar_sel == 2'(i))),
         .bar_wdata(bar_wdata),
         .addr     (addr),
         .hit      (hit_w[i]),
         .off      (off_w[i]),
         .rd       (rd_w[i])
      );
   end

   assign off_w[3] = '0;
   assign rd_w[3]  = '0;

   bwd_prio u_prio (
      .hit(hit_w),
      .idx(win)
   );

   assign rd_data = rd_w[rd_sel];

   always_ff @(posedge clk) begin
      if (!rst_n || !addr_vld) begin
         hit_vld  <= 1'b0;
         hit_csr  <= 1'b0;
         hit_sram <= 1'b0;
         hit_dram <= 1'b0;
         hit_idx  <= WIN_NONE;
         hit_off  <= '0;
      end else begin
         hit_vld  <= 1'b1;
         hit_csr  <= (win == WIN_CSR);
         hit_sram <= (win == WIN_SRAM);
         hit_dram <= (win == WIN_DRAM);
         hit_idx  <= win;
         hit_off  <= off_w[win];
      end
   end

endmodule

// File: rtl/bwd_chk.sv
module bwd_chk #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned CSR_LOG2 = 20
)(
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        rd_sel,
   input logic [ADDR_W-1:0] rd_data,
   input logic              addr_vld,
   input logic              hit_vld,
   input logic              hit_csr,
   input logic              hit_sram,
   input logic              hit_dram,
   input logic [1:0]        hit_idx,
   input logic [ADDR_W-1:0] hit_off
);

   p_vld_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld |=> hit_vld);

   p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_vld |=> (!hit_vld && !hit_csr && !hit_sram && !hit_dram
                     && hit_idx == 2'd3 && hit_off == '0));

   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_csr, hit_sram, hit_dram}));

   p_idx_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_idx == 2'd3) == !(hit_csr || hit_sram || hit_dram));

   p_csr_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit_csr |-> (hit_off >> CSR_LOG2) == '0);

   p_sram_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_sram |-> (hit_off >> 28) == '0);

   p_dram_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_dram |-> (hit_off >> 30) == '0);

   p_attr_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[2:0] == 3'b000);

   p_csr_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel == 2'd0 |-> rd_data[CSR_LOG2-1:0] == '0);

endmodule

bind bwd_top bwd_chk #(.ADDR_W(ADDR_W), .CSR_LOG2(CSR_LOG2)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_sel  (rd_sel),
   .rd_data (rd_data),
   .addr_vld(addr_vld),
   .hit_vld (hit_vld),
   .hit_csr (hit_csr),
   .hit_sram(hit_sram),
   .hit_dram(hit_dram),
   .hit_idx (hit_idx),
   .hit_off (hit_off)
);

// File: tb/sim_bwd_top.sv
module sim_bwd_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_mode = 1'b0;
   logic [1:0]  sram_strap = '0, dram_strap = '0;
   logic        msk_we = 1'b0;
   logic [1:0]  msk_sel = '0;
   logic [3:0]  msk_code = '0;
   logic        msk_pf = 1'b0;
   logic        bar_we = 1'b0;
   logic [1:0]  bar_sel = '0;
   logic [31:0] bar_wdata = '0;
   logic [1:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic [31:0] addr = '0;
   logic        addr_vld = 1'b0;
   logic        hit_vld, hit_csr, hit_sram, hit_dram;
   logic [1:0]  hit_idx;
   logic [31:0] hit_off;

   int n_run = 0, n_bad = 0;
   bit done = 0;

   // bench-side model of the window state
   int          e_csr = 20, e_sram = 0, e_dram = 0;
   logic [31:0] b_csr = '0, b_sram = '0, b_dram = '0;
   logic        pf_s = 1'b0, pf_d = 1'b0;

   always #4 clk = ~clk;

   bwd_top u0 (.*);

   function automatic int sram_loc(int c);
      return (c >= 1 && c <= 12) ? 16 + c : 0;
   endfunction
   function automatic int dram_loc(int c);
      return (c >= 1 && c <= 11) ? 19 + c : 0;
   endfunction
   function automatic logic [31:0] lom(int e);
      return (e == 0) ? 32'h0 : (32'h1 << e) - 32'h1;
   endfunction
   function automatic bit match(logic [31:0] a, logic [31:0] b, int e);
      return (e != 0) && ((a & ~lom(e)) == (b & ~lom(e)));
   endfunction
   function automatic int model_idx(logic [31:0] a);
      if (match(a, b_csr, e_csr))   return 0;
      if (match(a, b_sram, e_sram)) return 1;
      if (match(a, b_dram, e_dram)) return 2;
      return 3;
   endfunction
   function automatic logic [31:0] model_rd(logic [31:0] b, int e, logic pf);
      return (e == 0) ? 32'h0 : ((b & ~lom(e)) | (32'(pf) << 3));
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_bar(logic [1:0] s, logic [31:0] d);
      @(negedge clk);
      bar_we = 1'b1; bar_sel = s; bar_wdata = d;
      @(negedge clk);
      bar_we = 1'b0;
      if (s == 2'd0) b_csr = d;
      if (s == 2'd1) b_sram = d;
      if (s == 2'd2) b_dram = d;
   endtask

   task automatic wr_msk(logic [1:0] s, logic [3:0] c, logic pf);
      @(negedge clk);
      msk_we = 1'b1; msk_sel = s; msk_code = c; msk_pf = pf;
      @(negedge clk);
      msk_we = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [1:0] s, logic [31:0] exp);
      rd_sel = s;
      #1;
      chk(req, 64'(rd_data), 64'(exp));
   endtask

   task automatic probe(string req, logic [31:0] a);
      int ei, xe;
      logic [2:0] fl;
      @(negedge clk);
      addr = a; addr_vld = 1'b1;
      @(negedge clk);
      addr_vld = 1'b0;
      ei = model_idx(a);
      xe = (ei == 0) ? e_csr : (ei == 1) ? e_sram : (ei == 2) ? e_dram : 0;
      fl = (ei == 0) ? 3'b100 : (ei == 1) ? 3'b010 : (ei == 2) ? 3'b001 : 3'b000;
      chk({req, " vld"}, 64'(hit_vld), 64'(1));
      chk({req, " idx"}, 64'(hit_idx), 64'(ei));
      chk({req, " flags"}, 64'({hit_csr, hit_sram, hit_dram}), 64'(fl));
      chk({req, " off"}, 64'(hit_off), 64'((ei == 3) ? 32'h0 : (a & lom(xe))));
   endtask

   task automatic edges(string req, logic [31:0] b, int e);
      probe(req, b);
      if (e != 0) begin
         probe(req, b + lom(e));
         probe(req, b - 32'h1);
         probe(req, b + lom(e) + 32'h1);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11: reset state
      chk("R11 vld", 64'(hit_vld), 64'(0));
      chk("R11 idx", 64'(hit_idx), 64'(3));
      chk("R11 off", 64'(hit_off), 64'(0));
      rd_chk("R11 csr bar", 2'd0, 32'h0);
      rd_chk("R11 sram bar", 2'd1, 32'h0);
      rd_chk("R11 dram bar", 2'd2, 32'h0);
      rst_n = 1'b1;

      // R1: size discovery on the control-register BAR
      wr_bar(2'd0, 32'hFFFF_FFFF);
      rd_chk("R1 csr all-ones", 2'd0, 32'hFFF0_0000);
      wr_bar(2'd0, 32'hF000_0000);
      rd_chk("R1 csr base", 2'd0, 32'hF000_0000);
      edges("R1 csr edge", 32'hF000_0000, 20);
      wr_bar(2'd1, 32'h4000_0000);
      wr_bar(2'd2, 32'h8000_0000);

      // R6: switched-off windows after reset
      probe("R6 sram off", 32'h4000_0000);
      probe("R6 dram off", 32'h8000_0000);
      rd_chk("R6 sram rd", 2'd1, 32'h0);

      // R2 / R7 / R8: local SRAM sweep
      for (int c = 0; c < 16; c++) begin
         pf_s = c[0];
         wr_msk(2'd1, 4'(c), pf_s);
         e_sram = sram_loc(c);
         wr_bar(2'd1, 32'hFFFF_FFFF);
         rd_chk("R2 R7 sram size read", 2'd1, model_rd(32'hFFFF_FFFF, e_sram, pf_s));
         wr_bar(2'd1, 32'h4000_0000);
         rd_chk("R7 sram rd", 2'd1, model_rd(b_sram, e_sram, pf_s));
         edges("R2 R8 sram edge", 32'h4000_0000, e_sram);
      end

      // R3 / R7 / R8: local DRAM sweep
      for (int c = 0; c < 16; c++) begin
         pf_d = ~c[0];
         wr_msk(2'd2, 4'(c), pf_d);
         e_dram = dram_loc(c);
         wr_bar(2'd2, 32'hFFFF_FFFF);
         rd_chk("R3 R7 dram size read", 2'd2, model_rd(32'hFFFF_FFFF, e_dram, pf_d));
         wr_bar(2'd2, 32'h8000_0000);
         rd_chk("R7 dram rd", 2'd2, model_rd(b_dram, e_dram, pf_d));
         edges("R3 R8 dram edge", 32'h8000_0000, e_dram);
      end

      // R12: writes to the fixed window or to selector 3 are dropped
      wr_msk(2'd1, 4'd4, 1'b0); e_sram = 20; pf_s = 1'b0;
      wr_msk(2'd2, 4'd1, 1'b1); e_dram = 20; pf_d = 1'b1;
      wr_msk(2'd0, 4'd12, 1'b1);
      wr_msk(2'd3, 4'd12, 1'b1);
      rd_chk("R12 csr rd", 2'd0, 32'hF000_0000);
      rd_chk("R12 sram rd", 2'd1, model_rd(b_sram, e_sram, pf_s));
      rd_chk("R12 dram rd", 2'd2, model_rd(b_dram, e_dram, pf_d));
      probe("R12 csr edge", 32'hF010_0000);
      probe("R12 sram edge", 32'h4010_0000);
      probe("R12 dram edge", 32'h8010_0000);

      // R4: strap-sized SRAM, mask code would give 128 KB
      host_mode = 1'b1;
      wr_msk(2'd1, 4'd1, 1'b1); pf_s = 1'b1;
      wr_msk(2'd2, 4'd0, 1'b0); pf_d = 1'b0;
      dram_strap = 2'd0; e_dram = 27;
      for (int s = 0; s < 4; s++) begin
         sram_strap = 2'(s);
         e_sram = 25 + s;
         rd_chk("R4 R7 sram strap rd", 2'd1, model_rd(b_sram, e_sram, pf_s));
         edges("R4 sram strap edge", 32'h4000_0000, e_sram);
      end

      // R5: strap-sized DRAM, mask code 0 would switch it off
      for (int s = 0; s < 4; s++) begin
         dram_strap = 2'(s);
         e_dram = 27 + s;
         rd_chk("R5 dram strap rd", 2'd2, model_rd(b_dram, e_dram, pf_d));
         edges("R5 dram strap edge", 32'h8000_0000, e_dram);
      end

      // R9: overlapping windows, local mode
      host_mode = 1'b0;
      wr_msk(2'd1, 4'd12, 1'b0); e_sram = 28; pf_s = 1'b0;
      wr_msk(2'd2, 4'd11, 1'b0); e_dram = 30; pf_d = 1'b0;
      wr_bar(2'd1, 32'hF000_0000);
      wr_bar(2'd2, 32'hC000_0000);
      probe("R9 csr over sram", 32'hF000_0000);
      probe("R9 sram over dram", 32'hF010_0000);
      probe("R9 dram only", 32'hE000_0000);
      probe("R9 dram base", 32'hC000_0000);
      probe("R9 none", 32'h0000_1000);

      // R10: back-to-back valid, then idle clears
      @(negedge clk);
      addr = 32'hF000_0010; addr_vld = 1'b1;
      @(negedge clk);
      chk("R10 b2b first idx", 64'(hit_idx), 64'(0));
      chk("R10 b2b first off", 64'(hit_off), 64'(32'h10));
      addr = 32'hC000_0020;
      @(negedge clk);
      addr_vld = 1'b0;
      chk("R10 b2b second idx", 64'(hit_idx), 64'(2));
      chk("R10 b2b second off", 64'(hit_off), 64'(32'h20));
      @(negedge clk);
      chk("R10 idle vld", 64'(hit_vld), 64'(0));
      chk("R10 idle idx", 64'(hit_idx), 64'(3));
      chk("R10 idle off", 64'(hit_off), 64'(0));

      done = 1;
      summary();
      $finish;
   end

endmodule